// File: doc/BRIEF.md
# Programmable SPI Shift Sequencer

This block is a single-lane SPI master for short, arbitrary flash transactions. Software fills a bank of six transmit byte registers, programs the total number of SCLK cycles (plus an optional run of extra dummy cycles), unlocks the engine with a key value and sets the start bit. The engine then lowers chip select, shifts the transmit bytes out most significant bit first, and records every bit returned on MISO into an 80-bit capture chain. Software reads that chain back through ten capture byte registers.

The start bit reads back as one for as long as the transaction runs and drops by itself when chip select rises again, so software polls it for completion. A software reset bit returns the engine to idle and relocks it; the key must then be written again before any new transaction can start. The register port is a simple single-cycle write strobe with a combinational read mux.

Top module: `spiseq_top`

Register addresses (5-bit): transmit bytes 0..5 at 0x00..0x05; capture bytes 0..9 at 0x08..0x11; control 0x18 (start bit 2); bit count 0x19 (bits 5:0); dummy extension 0x1A (bits 1:0); key 0x1B; run control 0x1C (bit 0, 1 = run).

## Requirements
- R1: After reset chip select is high, SCLK is low, control bit 2 reads 0, key reads 0x00, run control reads 1 and every capture byte reads 0x00.
- R2: A start request (write with bit 2 set to address 0x18) is ignored unless the key register at 0x1B holds 0x30.
- R3: MOSI carries transmit byte 5 first, then bytes 4 down to 0, each MSB first; every bit after the 48th is 0.
- R4: The count register keeps bits 5:0 of a write, with any value above 56 stored as 56. Chip select stays low for exactly count plus dummy extension (0..3) SCLK rising edges.
- R5: SPI mode 0: SCLK is low whenever chip select is high, and MOSI never changes while SCLK is high.
- R6: Every bit sampled on an SCLK rise enters bit 0 of an 80-bit chain that is cleared at start. Capture byte i reads chain bits 8i+7..8i, so index 0 holds the newest eight bits.
- R7: Control bit 2 reads 1 from the start request until the transaction ends, then reads 0 with chip select high.
- R8: A start request or a count write while a transaction runs does not change or restart that transaction.
- R9: Writing 0 to run control bit 0 aborts at once: chip select rises, the capture chain clears and the key clears; starts are refused until 1 is written back and the key is written again.
- R10: A start request with count plus extension equal to zero does nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wen | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational) |
| spi_csn | output | 1 | Chip select, active low |
| spi_sclk | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data out |
| spi_miso | input | 1 | Serial data in |

## Verification
The bench targets the count clamp together with the dummy extension, where a design that forgot the clamp or the addition would hold chip select for the wrong number of edges, and the byte order on MOSI, where an ascending bank walk or LSB-first shifting shows as a mismatched bit vector. It fires start requests with no key, a wrong key and a zero count, where a loose launch gate would lower chip select, and a second start plus a count rewrite in mid-transaction, where a restart would show as an extra or longer frame. It aborts a long frame with the run bit, where a design that did not relock or clear the chain would start without a key or return stale capture bytes.

// File: rtl/spiseq_pkg.sv
package spiseq_pkg;

    localparam int AW        = 5;
    localparam int TX_BYTES  = 6;
    localparam int CAP_BYTES = 10;
    localparam int TX_W      = TX_BYTES * 8;
    localparam int CAP_W     = CAP_BYTES * 8;
    localparam int MAX_BITS  = 56;
    localparam int CNTF_W    = 6;
    localparam int EXTRA_W   = 2;
    localparam int CNT_W     = CNTF_W + 1;
    localparam int START_BIT = 2;

    localparam logic [7:0]    UNLOCK_KEY = 8'h30;
    localparam logic [AW-1:0] A_TX0      = 5'h00;
    localparam logic [AW-1:0] A_CAP0     = 5'h08;
    localparam logic [AW-1:0] A_CTRL     = 5'h18;
    localparam logic [AW-1:0] A_COUNT    = 5'h19;
    localparam logic [AW-1:0] A_EXTRA    = 5'h1A;
    localparam logic [AW-1:0] A_KEY      = 5'h1B;
    localparam logic [AW-1:0] A_RUN      = 5'h1C;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_LOW  = 2'd1,
        PH_HIGH = 2'd2
    } phase_e;

    typedef struct packed {
        logic             go;
        logic [TX_W-1:0]  tx;
        logic [CNT_W-1:0] total;
    } launch_t;

    function automatic logic [CNTF_W-1:0] clamp_count(input logic [CNTF_W-1:0] v);
        return (v > CNTF_W'(MAX_BITS)) ? CNTF_W'(MAX_BITS) : v;
    endfunction

endpackage

// File: rtl/spiseq_regs.sv
module spiseq_regs
    import spiseq_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wen,
    input  logic [AW-1:0]    addr,
    input  logic [7:0]       wdata,
    input  logic             busy,
    input  logic [CAP_W-1:0] cap,
    output logic [7:0]       rdata,
    output launch_t          launch,
    output logic             srst,
    output logic             key_ok
);

    logic [7:0]         tx_q [TX_BYTES];
    logic [CNTF_W-1:0]  count_q;
    logic [EXTRA_W-1:0] extra_q;
    logic [7:0]         key_q;
    logic               run_q;
    logic [CNT_W-1:0]   total;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < TX_BYTES; i++) tx_q[i] <= '0;
            count_q <= '0;
            extra_q <= '0;
            key_q   <= '0;
            run_q   <= 1'b1;
        end else begin
            if (wen) begin
                for (int i = 0; i < TX_BYTES; i++)
                    if (addr == A_TX0 + AW'(i)) tx_q[i] <= wdata;
                if (addr == A_COUNT) count_q <= clamp_count(wdata[CNTF_W-1:0]);
                if (addr == A_EXTRA) extra_q <= wdata[EXTRA_W-1:0];
                if (addr == A_KEY)   key_q   <= wdata;
                if (addr == A_RUN)   run_q   <= wdata[0];
            end
            if (!run_q) key_q <= '0;
        end
    end

    assign srst   = !run_q;
    assign key_ok = (key_q == UNLOCK_KEY);
    assign total  = CNT_W'(count_q) + CNT_W'(extra_q);

    always_comb begin
        launch       = '0;
        launch.go    = wen && (addr == A_CTRL) && wdata[START_BIT] && !busy
                       && key_ok && run_q && (total != '0);
        launch.total = total;
        for (int i = 0; i < TX_BYTES; i++) launch.tx[8*i +: 8] = tx_q[i];
    end

    always_comb begin
        rdata = '0;
        for (int i = 0; i < TX_BYTES; i++)
            if (addr == A_TX0 + AW'(i)) rdata = tx_q[i];
        for (int i = 0; i < CAP_BYTES; i++)
            if (addr == A_CAP0 + AW'(i)) rdata = cap[8*i +: 8];
        if (addr == A_CTRL)  rdata[START_BIT] = busy;
        if (addr == A_COUNT) rdata = 8'(count_q);
        if (addr == A_EXTRA) rdata = 8'(extra_q);
        if (addr == A_KEY)   rdata = key_q;
        if (addr == A_RUN)   rdata = {7'b0, run_q};
    end

    // R4: the stored count never exceeds the frame limit
    p_count_cap_r4: assert property (@(posedge clk) disable iff (rst)
        count_q <= CNTF_W'(MAX_BITS));

endmodule

// File: rtl/spiseq_tick.sv
module spiseq_tick #(
    parameter int DIV_HALF = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic tick
);

    localparam int CW = (DIV_HALF > 1) ? $clog2(DIV_HALF) : 1;

    logic [CW-1:0] cnt_q;

    assign tick = run && (cnt_q == CW'(DIV_HALF - 1));

    always_ff @(posedge clk) begin
        if (rst || !run)  cnt_q <= '0;
        else if (tick)    cnt_q <= '0;
        else              cnt_q <= cnt_q + 1'b1;
    end

endmodule

// File: rtl/spiseq_shifter.sv
module spiseq_shifter
    import spiseq_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             srst,
    input  launch_t          launch,
    input  logic             tick,
    input  logic             miso,
    output logic             csn,
    output logic             sclk,
    output logic             mosi,
    output logic             busy,
    output logic [CAP_W-1:0] cap
);

    phase_e           ph;
    logic [TX_W-1:0]  tx_sh;
    logic [CNT_W-1:0] left_q;
    logic [CNT_W-1:0] rises_q;
    logic [CNT_W-1:0] tot_q;

    assign busy = (ph != PH_IDLE);

    always_ff @(posedge clk) begin
        if (rst || srst) begin
            ph      <= PH_IDLE;
            csn     <= 1'b1;
            sclk    <= 1'b0;
            mosi    <= 1'b0;
            cap     <= '0;
            tx_sh   <= '0;
            left_q  <= '0;
            rises_q <= '0;
            tot_q   <= '0;
        end else begin
            unique case (ph)
                PH_IDLE: begin
                    if (launch.go) begin
                        ph      <= PH_LOW;
                        csn     <= 1'b0;
                        mosi    <= launch.tx[TX_W-1];
                        tx_sh   <= launch.tx << 1;
                        left_q  <= launch.total;
                        tot_q   <= launch.total;
                        rises_q <= '0;
                        cap     <= '0;
                    end
                end
                PH_LOW: begin
                    if (tick) begin
                        sclk    <= 1'b1;
                        cap     <= {cap[CAP_W-2:0], miso};
                        left_q  <= left_q - 1'b1;
                        rises_q <= rises_q + 1'b1;
                        ph      <= PH_HIGH;
                    end
                end
                PH_HIGH: begin
                    if (tick) begin
                        sclk <= 1'b0;
                        if (left_q == '0) begin
                            ph   <= PH_IDLE;
                            csn  <= 1'b1;
                            mosi <= 1'b0;
                        end else begin
                            mosi  <= tx_sh[TX_W-1];
                            tx_sh <= tx_sh << 1;
                            ph    <= PH_LOW;
                        end
                    end
                end
                default: ph <= PH_IDLE;
            endcase
        end
    end

    // R5: clock idles low outside a frame
    p_sclk_idle_r5: assert property (@(posedge clk) disable iff (rst)
        csn |-> !sclk);

    // R5: data out holds while the clock is high
    p_mosi_hold_r5: assert property (@(posedge clk) disable iff (rst)
        (sclk && $past(sclk)) |-> $stable(mosi));

    // R4: edges taken plus edges remaining always equal the frame length
    p_edge_sum_r4: assert property (@(posedge clk) disable iff (rst)
        busy |-> (CNT_W'(rises_q + left_q) == tot_q));

    // R8: a running frame keeps its length
    p_len_fixed_r8: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy)) |-> $stable(tot_q));

endmodule

// File: rtl/spiseq_top.sv
module spiseq_top
    import spiseq_pkg::*;
#(
    parameter int DIV_HALF = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       reg_wen,
    input  logic [4:0] reg_addr,
    input  logic [7:0] reg_wdata,
    output logic [7:0] reg_rdata,
    output logic       spi_csn,
    output logic       spi_sclk,
    output logic       spi_mosi,
    input  logic       spi_miso
);

    launch_t          launch;
    logic             busy;
    logic             srst;
    logic             key_ok;
    logic             tick;
    logic [CAP_W-1:0] cap;

    spiseq_regs u_regs (
        .clk    (clk),
        .rst    (rst),
        .wen    (reg_wen),
        .addr   (reg_addr),
        .wdata  (reg_wdata),
        .busy   (busy),
        .cap    (cap),
        .rdata  (reg_rdata),
        .launch (launch),
        .srst   (srst),
        .key_ok (key_ok)
    );

    spiseq_tick #(.DIV_HALF(DIV_HALF)) u_tick (
        .clk  (clk),
        .rst  (rst),
        .run  (busy),
        .tick (tick)
    );

    spiseq_shifter u_shift (
        .clk    (clk),
        .rst    (rst),
        .srst   (srst),
        .launch (launch),
        .tick   (tick),
        .miso   (spi_miso),
        .csn    (spi_csn),
        .sclk   (spi_sclk),
        .mosi   (spi_mosi),
        .busy   (busy),
        .cap    (cap)
    );

    // R2: chip select only falls when the key was in place
    p_key_gate_r2: assert property (@(posedge clk) disable iff (rst)
        $fell(spi_csn) |-> $past(key_ok));

endmodule

// File: tb/tb_spiseq_top.sv
module tb_spiseq_top;
    import spiseq_pkg::*;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wen = 1'b0;
    logic [4:0] addr = '0;
    logic [7:0] wdata = '0;
    logic       miso;
    wire  [7:0] rdata;
    wire        csn, sclk, mosi;

    always #4 clk = ~clk;

    spiseq_top dut (
        .clk(clk), .rst(rst), .reg_wen(wen), .reg_addr(addr), .reg_wdata(wdata),
        .reg_rdata(rdata), .spi_csn(csn), .spi_sclk(sclk), .spi_mosi(mosi),
        .spi_miso(miso)
    );

    typedef struct {
        logic [63:0] bits;
        int          total;
        bit          aborted;
    } exp_t;

    exp_t        q[$];
    exp_t        e;
    int          errors = 0;
    int          checks = 0;
    int          n = 0;
    logic [63:0] got = '0;
    logic [63:0] miso_pat = '0;
    bit          mosi_bad = 0;
    bit          cs_seen = 0;
    bit          done = 0;

    always_comb miso = (n < 64) ? miso_pat[63 - n] : 1'b0;

    task automatic chk(input bit ok, input string tag, input logic [79:0] act, input logic [79:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic finish_up();
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    // monitor: collects each frame and compares it with the queued expectation
    always @(negedge csn) if (!rst) begin
        n = 0; got = '0; mosi_bad = 0; cs_seen = 1;
    end
    always @(posedge sclk) if (!csn && !rst) begin
        if (n < 64) got[63 - n] = mosi;
        n++;
    end
    always @(mosi) if (sclk && !rst) mosi_bad = 1;
    always @(posedge csn) if (!rst) begin
        if (q.size() == 0) chk(0, "R8 unexpected frame", 80'(n), 0);
        else begin
            e = q.pop_front();
            if (e.aborted) chk(n < e.total, "R9 aborted frame shorter", 80'(n), 80'(e.total));
            else begin
                chk(n == e.total, "R4 rising edge count", 80'(n), 80'(e.total));
                chk(got == e.bits, "R3 MOSI bit order", 80'(got), 80'(e.bits));
                chk(!mosi_bad, "R5 MOSI changed with SCLK high", 80'(mosi_bad), 0);
            end
        end
    end

    task automatic wr(input logic [4:0] a, input logic [7:0] d);
        @(negedge clk); wen = 1'b1; addr = a; wdata = d;
        @(negedge clk); wen = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [7:0] d);
        @(negedge clk); addr = a; #1; d = rdata;
    endtask

    function automatic logic [63:0] exp_mosi(input logic [47:0] tx, input int total);
        logic [63:0] v = {tx, 16'h0};
        for (int k = 0; k < 64; k++) if (k >= total) v[63 - k] = 1'b0;
        return v;
    endfunction

    function automatic logic [79:0] exp_cap(input logic [63:0] pat, input int total);
        logic [79:0] c = '0;
        for (int j = 0; j < total; j++) c[j] = pat[64 - total + j];
        return c;
    endfunction

    task automatic wait_idle();
        logic [7:0] d;
        for (int i = 0; i < 3000; i++) begin
            rd(A_CTRL, d);
            if (!d[START_BIT]) break;
        end
    endtask

    task automatic load(input logic [47:0] tx, input int cnt, input int extra);
        for (int i = 0; i < TX_BYTES; i++) wr(A_TX0 + 5'(i), tx[8*i +: 8]);
        wr(A_COUNT, 8'(cnt));
        wr(A_EXTRA, 8'(extra));
    endtask

    task automatic run_txn(input logic [47:0] tx, input int cnt, input int extra,
                           input logic [63:0] pat);
        logic [7:0]  d;
        logic [79:0] c;
        exp_t        x;
        int          total;
        load(tx, cnt, extra);
        total = ((cnt > MAX_BITS) ? MAX_BITS : cnt) + extra;
        miso_pat = pat;
        x.bits = exp_mosi(tx, total); x.total = total; x.aborted = 0;
        q.push_back(x);
        wr(A_CTRL, 8'h04);
        rd(A_CTRL, d);
        chk(d[START_BIT] == 1'b1, "R7 start bit reads 1 while running", 80'(d), 80'h04);
        wait_idle();
        chk(csn == 1'b1, "R7 chip select high once start bit clears", 80'(csn), 1);
        c = exp_cap(pat, total);
        for (int i = 0; i < CAP_BYTES; i++) begin
            rd(A_CAP0 + 5'(i), d);
            chk(d == c[8*i +: 8], "R6 capture byte", 80'(d), 80'(c[8*i +: 8]));
        end
    endtask

    initial begin
        #(8 * 150000);
        chk(0, "watchdog expired", 0, 0);
        finish_up();
    end

    initial begin
        logic [7:0] d;
        exp_t       x;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1: reset state
        chk(csn == 1'b1 && sclk == 1'b0, "R1 pins idle after reset", 80'({csn, sclk}), 80'h2);
        rd(A_CTRL, d);  chk(d == 8'h00, "R1 control reads 0", 80'(d), 0);
        rd(A_KEY, d);   chk(d == 8'h00, "R1 key reads 0", 80'(d), 0);
        rd(A_RUN, d);   chk(d == 8'h01, "R1 run bit reads 1", 80'(d), 1);
        rd(A_CAP0, d);  chk(d == 8'h00, "R1 capture 0 reads 0", 80'(d), 0);
        rd(A_CAP0 + 5'd9, d); chk(d == 8'h00, "R1 capture 9 reads 0", 80'(d), 0);

        // R2: no key, then wrong key
        load(48'h9F_00_00_00_00_00, 8, 0);
        cs_seen = 0;
        wr(A_CTRL, 8'h04);
        repeat (20) @(negedge clk);
        chk(!cs_seen, "R2 start without key ignored", 80'(cs_seen), 0);
        wr(A_KEY, 8'h31);
        wr(A_CTRL, 8'h04);
        repeat (20) @(negedge clk);
        chk(!cs_seen, "R2 start with wrong key ignored", 80'(cs_seen), 0);
        rd(A_CTRL, d); chk(d == 8'h00, "R2 start bit stays 0", 80'(d), 0);
        wr(A_KEY, UNLOCK_KEY);

        // R10: zero-length frame
        wr(A_COUNT, 8'd0); wr(A_EXTRA, 8'd0);
        wr(A_CTRL, 8'h04);
        repeat (20) @(negedge clk);
        chk(!cs_seen, "R10 zero count does nothing", 80'(cs_seen), 0);

        // main function, several patterns
        run_txn(48'h9F_11_22_33_44_55, 8, 0, 64'h0);
        run_txn(48'h03_12_34_56_00_00, 32, 0, 64'h0000_00A5_0000_0000);
        run_txn(48'h0B_AB_CD_EF_5A_C3, 56, 2, 64'hDEAD_BEEF_CAFE_F00D);
        wr(A_COUNT, 8'd63);
        rd(A_COUNT, d); chk(d == 8'd56, "R4 count clamps to 56", 80'(d), 56);
        run_txn(48'hFF_80_01_7E_81_42, 63, 3, 64'h1234_5678_9ABC_DEF0);
        run_txn(48'h80_00_00_00_00_00, 1, 0, 64'h8000_0000_0000_0000);

        // R8: start and count rewrite while busy
        load(48'h05_A0_B0_C0_D0_E0, 24, 0);
        miso_pat = 64'h0F0F_0F0F_0F0F_0F0F;
        x.bits = exp_mosi(48'h05_A0_B0_C0_D0_E0, 24); x.total = 24; x.aborted = 0;
        q.push_back(x);
        wr(A_CTRL, 8'h04);
        wr(A_COUNT, 8'd40);
        wr(A_CTRL, 8'h04);
        wait_idle();
        repeat (30) @(negedge clk);
        chk(q.size() == 0, "R8 no restart after busy start", 80'(q.size()), 0);

        // R9: abort by run control
        load(48'hAA_55_AA_55_AA_55, 56, 0);
        miso_pat = 64'hFFFF_FFFF_FFFF_FFFF;
        x.bits = '0; x.total = 56; x.aborted = 1;
        q.push_back(x);
        wr(A_CTRL, 8'h04);
        repeat (40) @(negedge clk);
        wr(A_RUN, 8'h00);
        @(negedge clk);
        chk(csn == 1'b1, "R9 chip select rises on abort", 80'(csn), 1);
        rd(A_KEY, d);  chk(d == 8'h00, "R9 key cleared", 80'(d), 0);
        rd(A_CAP0, d); chk(d == 8'h00, "R9 capture cleared", 80'(d), 0);
        wr(A_RUN, 8'h01);
        cs_seen = 0;
        wr(A_CTRL, 8'h04);
        repeat (20) @(negedge clk);
        chk(!cs_seen, "R9 start refused until key rewritten", 80'(cs_seen), 0);
        wr(A_KEY, UNLOCK_KEY);
        run_txn(48'h06_00_00_00_00_00, 16, 1, 64'h5A5A_0000_0000_0000);

        repeat (10) @(negedge clk);
        chk(q.size() == 0, "R4 every queued frame observed", 80'(q.size()), 0);
        finish_up();
    end

endmodule